// File: doc/BRIEF.md
# Dual-Register Pseudo-Noise Chip Generator

This block produces a one-bit pseudo-noise chip stream for direct-sequence spread-spectrum transmitters. Inside it, two 8-bit linear feedback shift registers with different feedback tap pairs run in lockstep. A third, 17-stage register gives a longer maximal-length sequence. A two-bit selector picks which stream drives the chip output: either short register alone as a noise source, the exclusive-OR of both short registers as a Gold-style spreading code, or the long register.

The registers shift toward the MSB once per enabled clock cycle, and the feedback bit enters at bit 0. The chip is the current MSB of the selected register or registers. A load strobe writes new seeds into all three registers at once and takes priority over the enable. A seed of all zeros would stall a register forever, so such a seed is replaced with the value 1. The full contents of each register are brought out as parallel words.

Top module: `pn_chip_gen`

## Requirements
- R1: After reset, both short registers hold 8'h01 and the long register holds 17'h00001.
- R2: When en=1 and load=0, register A becomes {A[6:0], A[7]^A[1]} on the next clock edge.
- R3: When en=1 and load=0, register B becomes {B[6:0], B[7]^B[3]} on the next clock edge.
- R4: When en=1 and load=0, the long register L becomes {L[15:0], L[16]^L[13]} on the next clock edge (taps at stages 17 and 14).
- R5: When en=0 and load=0, all three registers keep their values.
- R6: When load=1, each register takes its seed input on the next clock edge, whatever the value of en.
- R7: A seed of all zeros is loaded as the value 1 (8'h01 or 17'h00001).
- R8: mode=0 drives chip with A[7], and mode=1 drives it with B[7].
- R9: mode=2 drives chip with A[7]^B[7].
- R10: mode=3 drives chip with L[16].
- R11: None of the registers is ever all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Advances all registers by one chip |
| load | input | 1 | Writes the seeds into all registers. Overrides en |
| seed_a | input | 8 | Seed for register A |
| seed_b | input | 8 | Seed for register B |
| seed_l | input | 17 | Seed for the long register |
| mode | input | 2 | Chip source: 0=A, 1=B, 2=A^B, 3=long |
| chip | output | 1 | Current chip bit |
| state_a | output | 8 | Contents of register A |
| state_b | output | 8 | Contents of register B |
| state_l | output | 17 | Contents of the long register |

## Verification
The step and hold properties compare each register with its own value one cycle earlier. They therefore assume that en, load and the seeds do not change between clock edges. The bench meets this by driving every input on the falling edge. The chip-selection properties assume that mode is a settled 2-bit value at each rising edge, and the bench only changes mode together with the other inputs. The non-zero property holds only if the stepping keeps a non-zero state non-zero. The stimulus therefore includes all-zero seeds, so that the substitution of 1 is exercised along with long free-running stretches.

// File: rtl/pn_pkg.sv
package pn_pkg;
  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_GOLD = 2'd2,
    SEL_LONG = 2'd3
  } chip_sel_e;

  // Fibonacci step: shift toward MSB, feedback from two taps enters bit 0
  function automatic logic [31:0] fib_next(input logic [31:0] st, input int w,
                                           input int hi, input int lo);
    logic [31:0] nx;
    nx = (st << 1) | {31'd0, st[hi] ^ st[lo]};
    for (int i = 0; i < 32; i++) if (i >= w) nx[i] = 1'b0;
    return nx;
  endfunction
endpackage

// File: rtl/pn_lfsr.sv
module pn_lfsr #(
  parameter int W      = 8,
  parameter int TAP_HI = 7,
  parameter int TAP_LO = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         load,
  input  logic [W-1:0] seed,
  output logic [W-1:0] state
);
  localparam logic [W-1:0] DFLT = W'(1);

  logic [W-1:0] safe_seed;
  logic [W-1:0] stepped;
  logic [31:0]  wide_next;

  assign safe_seed = (seed == '0) ? DFLT : seed;
  assign wide_next = pn_pkg::fib_next(32'(state), W, TAP_HI, TAP_LO);
  assign stepped   = wide_next[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state <= DFLT;
    else if (load)  state <= safe_seed;
    else if (adv)   state <= stepped;
  end
endmodule

// File: rtl/pn_out_sel.sv
module pn_out_sel (
  input  pn_pkg::chip_sel_e sel,
  input  logic              a_msb,
  input  logic              b_msb,
  input  logic              l_msb,
  output logic              chip
);
  always_comb begin
    unique case (sel)
      pn_pkg::SEL_A:    chip = a_msb;
      pn_pkg::SEL_B:    chip = b_msb;
      pn_pkg::SEL_GOLD: chip = a_msb ^ b_msb;
      default:          chip = l_msb;
    endcase
  end
endmodule

// File: rtl/pn_chip_gen.sv
module pn_chip_gen #(
  parameter int SW    = 8,
  parameter int LW    = 17,
  parameter int TA_LO = 1,
  parameter int TB_LO = 3,
  parameter int TL_LO = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic [SW-1:0] seed_a,
  input  logic [SW-1:0] seed_b,
  input  logic [LW-1:0] seed_l,
  input  logic [1:0]    mode,
  output logic          chip,
  output logic [SW-1:0] state_a,
  output logic [SW-1:0] state_b,
  output logic [LW-1:0] state_l
);
  // named internal event for the checker
  logic adv_evt;
  assign adv_evt = en & ~load;

  pn_lfsr #(.W(SW), .TAP_HI(SW-1), .TAP_LO(TA_LO)) u_reg_a (
    .clk(clk), .rst_n(rst_n), .adv(adv_evt), .load(load),
    .seed(seed_a), .state(state_a));

  pn_lfsr #(.W(SW), .TAP_HI(SW-1), .TAP_LO(TB_LO)) u_reg_b (
    .clk(clk), .rst_n(rst_n), .adv(adv_evt), .load(load),
    .seed(seed_b), .state(state_b));

  pn_lfsr #(.W(LW), .TAP_HI(LW-1), .TAP_LO(TL_LO)) u_reg_l (
    .clk(clk), .rst_n(rst_n), .adv(adv_evt), .load(load),
    .seed(seed_l), .state(state_l));

  pn_out_sel u_sel (
    .sel(pn_pkg::chip_sel_e'(mode)),
    .a_msb(state_a[SW-1]), .b_msb(state_b[SW-1]), .l_msb(state_l[LW-1]),
    .chip(chip));
endmodule

// File: rtl/pn_chip_gen_chk.sv
module pn_chip_gen_chk #(
  parameter int SW    = 8,
  parameter int LW    = 17,
  parameter int TA_LO = 1,
  parameter int TB_LO = 3,
  parameter int TL_LO = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          load,
  input logic          adv_evt,
  input logic [SW-1:0] seed_a,
  input logic [SW-1:0] seed_b,
  input logic [LW-1:0] seed_l,
  input logic [1:0]    mode,
  input logic          chip,
  input logic [SW-1:0] state_a,
  input logic [SW-1:0] state_b,
  input logic [LW-1:0] state_l
);
  // R2
  a_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> (state_a[SW-1:1] == $past(state_a[SW-2:0])) &&
                (state_a[0] == ($past(state_a[SW-1]) ^ $past(state_a[TA_LO]))));
  // R3
  b_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> (state_b[SW-1:1] == $past(state_b[SW-2:0])) &&
                (state_b[0] == ($past(state_b[SW-1]) ^ $past(state_b[TB_LO]))));
  // R4
  l_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> (state_l[LW-1:1] == $past(state_l[LW-2:0])) &&
                (state_l[0] == ($past(state_l[LW-1]) ^ $past(state_l[TL_LO]))));
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(state_a) && $stable(state_b) && $stable(state_l));
  // R6
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && seed_a != '0 && seed_b != '0 && seed_l != '0) |=>
      (state_a == $past(seed_a)) && (state_b == $past(seed_b)) && (state_l == $past(seed_l)));
  // R7
  zero_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && seed_a == '0) |=> (state_a == SW'(1)));
  // R9
  gold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> (chip == (state_a[SW-1] ^ state_b[SW-1])));
  // R10
  long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> (chip == state_l[LW-1]));
  // R11
  nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_a != '0) && (state_b != '0) && (state_l != '0));
endmodule

bind pn_chip_gen pn_chip_gen_chk #(.SW(SW), .LW(LW), .TA_LO(TA_LO), .TB_LO(TB_LO), .TL_LO(TL_LO))
  u_chk (.*);

// File: tb/sim_pn_chip_gen.sv
module sim_pn_chip_gen;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, load = 1'b0;
  logic [7:0]  seed_a = '0, seed_b = '0;
  logic [16:0] seed_l = '0;
  logic [1:0]  mode = 2'd0;
  logic        chip;
  logic [7:0]  state_a, state_b;
  logic [16:0] state_l;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct {
    logic [7:0]  a;
    logic [7:0]  b;
    logic [16:0] l;
    logic        c;
    string       tag_a, tag_b, tag_l, tag_c;
  } exp_t;
  exp_t q[$];

  // reference model state
  logic [7:0]  ma = 8'h01, mb = 8'h01;
  logic [16:0] ml = 17'h1;

  pn_chip_gen u0 (.clk(clk), .rst_n(rst_n), .en(en), .load(load),
    .seed_a(seed_a), .seed_b(seed_b), .seed_l(seed_l), .mode(mode),
    .chip(chip), .state_a(state_a), .state_b(state_b), .state_l(state_l));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic model_chip(input logic [1:0] m);
    case (m)
      2'd0: return ma[7];               // R8
      2'd1: return mb[7];               // R8
      2'd2: return ma[7] ^ mb[7];       // R9
      default: return ml[16];           // R10
    endcase
  endfunction

  function automatic string chip_tag(input logic [1:0] m);
    case (m)
      2'd0, 2'd1: return "R8";
      2'd2:       return "R9";
      default:    return "R10";
    endcase
  endfunction

  // driver: one cycle of stimulus, pushes the expected result
  task automatic drive(input logic e, input logic ld, input logic [1:0] m,
                       input logic [7:0] sa, input logic [7:0] sb, input logic [16:0] sl);
    exp_t it;
    @(negedge clk);
    en = e; load = ld; mode = m; seed_a = sa; seed_b = sb; seed_l = sl;
    if (ld) begin
      ma = (sa == 0) ? 8'h01 : sa;
      mb = (sb == 0) ? 8'h01 : sb;
      ml = (sl == 0) ? 17'h1 : sl;
      it.tag_a = (sa == 0) ? "R7" : "R6";
      it.tag_b = (sb == 0) ? "R7" : "R6";
      it.tag_l = (sl == 0) ? "R7" : "R6";
    end else if (e) begin
      ma = {ma[6:0], ma[7] ^ ma[1]};
      mb = {mb[6:0], mb[7] ^ mb[3]};
      ml = {ml[15:0], ml[16] ^ ml[13]};
      it.tag_a = "R2"; it.tag_b = "R3"; it.tag_l = "R4";
    end else begin
      it.tag_a = "R5"; it.tag_b = "R5"; it.tag_l = "R5";
    end
    it.a = ma; it.b = mb; it.l = ml;
    it.c = model_chip(m); it.tag_c = chip_tag(m);
    q.push_back(it);
  endtask

  // monitor: compares after each rising edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      chk(it.tag_a, 32'(state_a), 32'(it.a));
      chk(it.tag_b, 32'(state_b), 32'(it.b));
      chk(it.tag_l, 32'(state_l), 32'(it.l));
      chk(it.tag_c, 32'(chip), 32'(it.c));
      // R11
      chk("R11", 32'(state_a != 0 && state_b != 0 && state_l != 0), 32'd1);
    end
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 3 + 2);
    // R1: reset state
    chk("R1", 32'(state_a), 32'h01);
    chk("R1", 32'(state_b), 32'h01);
    chk("R1", 32'(state_l), 32'h1);
    chk("R8", 32'(chip), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 20; i++) drive(1, 0, 2'd0, 0, 0, 0);
    for (int i = 0; i < 20; i++) drive(1, 0, 2'd1, 0, 0, 0);
    for (int i = 0; i < 30; i++) drive(1, 0, 2'd2, 0, 0, 0);
    for (int i = 0; i < 40; i++) drive(1, 0, 2'd3, 0, 0, 0);
    for (int i = 0; i < 6; i++)  drive(0, 0, 2'(i), 0, 0, 0);       // R5 hold
    drive(0, 1, 2'd2, 8'hA5, 8'h3C, 17'h1F0F0);                     // R6 load, en low
    for (int i = 0; i < 10; i++) drive(1, 0, 2'd2, 0, 0, 0);
    drive(1, 1, 2'd3, 8'h80, 8'hFF, 17'h10000);                     // R6 load beats en
    for (int i = 0; i < 25; i++) drive(1, 0, 2'(i), 0, 0, 0);
    drive(1, 1, 2'd0, 8'h00, 8'h00, 17'h0);                         // R7 zero seeds
    drive(0, 1, 2'd1, 8'h00, 8'h5A, 17'h0);                         // R7 mixed
    for (int i = 0; i < 400; i++) drive(i % 7 != 3, 0, 2'(i / 50), 0, 0, 0);
    @(negedge clk); en = 0;
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule